// File: doc/BRIEF.md
# Receive Window Timer Unit

This block times the receive window of a reader that has just finished transmitting. Three count-down timers run on a carrier-derived step enable (`tick`, one pulse per 64 carrier periods). The first is the mask timer. It keeps `rxOn` low for a programmed time after end of transmission and then raises it. The second is the no-response timer. It raises an interrupt when no reply has begun within a programmed time. The third is a general-purpose timer. A start-of-reply pulse, an end-of-reply pulse or a command can start it, and it interrupts when it runs out.

The surrounding framing logic supplies the end-of-transmit, reply-start and reply-end pulses and the reply-busy level. The command decoder supplies the clear and start pulses. The register file supplies timeout values and mode bits, and the block latches these when each timer starts. Interrupt flags leave the block as one-cycle pulses.

Top module: `rxwin_timers`

## Requirements
- R1: While `rst` is held, and after it is released with no stimulus, `rxOn`, `irqNrt` and `irqGpt` are all 0.
- R2: An `eot` pulse starts the mask timer and the no-response timer. The next cycle shows `rxOn` low if `cfgMask` is nonzero, and high if `cfgMask` is zero.
- R3: The mask timer drives `rxOn` high once `cfgMask` steps have passed. A step is 1 tick, or 8 ticks when `lowPower` is 1. The mask timer never raises an interrupt.
- R4: A no-response step is 1 tick when `nrtLong` is 0 and 64 ticks when it is 1. The flag `irqNrt` pulses `cfgNrt` steps after the start.
- R5: Default mode (`nrtAlwaysCfg`=0): at expiry `irqNrt` pulses and `rxOn` goes low. A `replyStart` pulse that arrives first stops the timer, and no interrupt follows.
- R6: Always-interrupt mode (`nrtAlwaysCfg`=1): the timer ignores `replyStart` and always pulses `irqNrt` at expiry. It pulls `rxOn` low only when `replyBusy` is 0 in the expiry cycle.
- R7: `cmdClear` stops all three timers, except a no-response timer that was started in always-interrupt mode.
- R8: A `cmdStartNrt` or `cmdStartGpt` pulse restarts its timer from the full value, even if that timer is already running.
- R9: `gptTrig` selects what starts the general-purpose timer besides `cmdStartGpt`: 0 or 3 means the command only, 1 means `replyStart`, 2 means `replyEnd`. The flag `irqGpt` pulses `cfgGpt` ticks after the start.
- R10: A start with a timeout value of zero leaves that timer stopped, so it never expires or interrupts.
- R11: Timeout values and mode bits are captured when a timer starts. Changing them while it runs has no effect until the next start.
- R12: Each interrupt flag is a single-cycle pulse. A start or stop in the final tick's cycle takes priority over expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Carrier step enable, one per 64 carrier periods |
| eot | input | 1 | End-of-transmit pulse |
| replyStart | input | 1 | Reply start-of-frame pulse |
| replyEnd | input | 1 | Reply end-of-frame pulse |
| replyBusy | input | 1 | Reply being processed (level) |
| cmdClear | input | 1 | Clear-timers command pulse |
| cmdStartNrt | input | 1 | Start no-response timer command pulse |
| cmdStartGpt | input | 1 | Start general-purpose timer command pulse |
| lowPower | input | 1 | Mask timer step of 8 ticks |
| nrtLong | input | 1 | No-response step of 64 ticks |
| nrtAlwaysCfg | input | 1 | No-response always-interrupt mode |
| gptTrig | input | 2 | General-purpose trigger select |
| cfgMask | input | TMR_W | Mask timeout in steps |
| cfgNrt | input | TMR_W | No-response timeout in steps |
| cfgGpt | input | TMR_W | General-purpose timeout in ticks |
| rxOn | output | 1 | Receiver-on level |
| irqNrt | output | 1 | No-response interrupt pulse |
| irqGpt | output | 1 | General-purpose interrupt pulse |

## Verification
The assertions assume that `eot`, the reply pulses and the command pulses last exactly one cycle. They also assume that `replyBusy` and the configuration inputs are steady across each rising edge. Under those conditions, `$past(replyBusy)` at an interrupt is the value that decided the force-low. The stimulus is applied on falling clock edges. It drops every pulse after one cycle and changes configuration only between edges, including in the random phase, where pulses of every kind are allowed to coincide.

// File: rtl/rxwin_pkg.sv
package rxwin_pkg;
  localparam int NUM_TMR = 3;
  localparam int T_MASK  = 0;
  localparam int T_NRT   = 1;
  localparam int T_GPT   = 2;

  typedef enum logic [1:0] {
    GPT_TRIG_CMD     = 2'd0,
    GPT_TRIG_RXSTART = 2'd1,
    GPT_TRIG_RXEND   = 2'd2,
    GPT_TRIG_CMD_ALT = 2'd3
  } gptTrig_e;

  // control -> datapath strobes, one bit per timer
  typedef struct packed {
    logic [NUM_TMR-1:0] start;
    logic [NUM_TMR-1:0] stop;
  } tmrStrobe_t;
endpackage

// File: rtl/rxwin_dp.sv
module rxwin_dp
  import rxwin_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int PRE_W = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           tick,
  input  tmrStrobe_t                     strobe,
  input  logic [NUM_TMR-1:0][TMR_W-1:0]  loadVal,
  input  logic [NUM_TMR-1:0][PRE_W-1:0]  divM1,
  output logic [NUM_TMR-1:0]             hit
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic [TMR_W-1:0] cnt;
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] lim;
    logic             run;

    always_ff @(posedge clk) begin
      if (rst) begin
        run <= 1'b0;
        cnt <= '0;
        pre <= '0;
        lim <= '0;
      end else if (strobe.start[i]) begin
        run <= (loadVal[i] != '0);
        cnt <= loadVal[i];
        pre <= '0;
        lim <= divM1[i];
      end else if (strobe.stop[i]) begin
        run <= 1'b0;
      end else if (run && tick) begin
        if (pre == lim) begin
          pre <= '0;
          cnt <= cnt - 1'b1;
          if (cnt == TMR_W'(1)) run <= 1'b0;
        end else begin
          pre <= pre + 1'b1;
        end
      end
    end

    // final tick of a run, unless a start or stop claims this cycle
    assign hit[i] = run && tick && (pre == lim) && (cnt == TMR_W'(1))
                    && !strobe.start[i] && !strobe.stop[i];
  end
endmodule

// File: rtl/rxwin_ctrl.sv
module rxwin_ctrl
  import rxwin_pkg::*;
#(
  parameter int TMR_W    = 8,
  parameter int PRE_W    = 6,
  parameter int LP_DIV   = 8,
  parameter int LONG_DIV = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          eot,
  input  logic                          replyStart,
  input  logic                          replyEnd,
  input  logic                          replyBusy,
  input  logic                          cmdClear,
  input  logic                          cmdStartNrt,
  input  logic                          cmdStartGpt,
  input  logic                          lowPower,
  input  logic                          nrtLong,
  input  logic                          nrtAlwaysCfg,
  input  logic [1:0]                    gptTrig,
  input  logic [TMR_W-1:0]              cfgMask,
  input  logic [NUM_TMR-1:0]            hit,
  output tmrStrobe_t                    strobe,
  output logic [NUM_TMR-1:0][PRE_W-1:0] divM1,
  output logic                          nrtAlways,
  output logic                          rxOn,
  output logic                          irqNrt,
  output logic                          irqGpt
);
  logic gptFire;
  logic nrtForceLow;

  always_comb begin
    gptFire = cmdStartGpt
            || (gptTrig == GPT_TRIG_RXSTART && replyStart)
            || (gptTrig == GPT_TRIG_RXEND   && replyEnd);

    strobe.start[T_MASK] = eot;
    strobe.start[T_NRT]  = eot || cmdStartNrt;
    strobe.start[T_GPT]  = gptFire;

    strobe.stop[T_MASK]  = cmdClear;
    strobe.stop[T_NRT]   = !nrtAlways && (cmdClear || replyStart);
    strobe.stop[T_GPT]   = cmdClear;

    divM1[T_MASK] = lowPower ? PRE_W'(LP_DIV - 1)   : '0;
    divM1[T_NRT]  = nrtLong  ? PRE_W'(LONG_DIV - 1) : '0;
    divM1[T_GPT]  = '0;

    nrtForceLow = hit[T_NRT] && (!nrtAlways || !replyBusy);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nrtAlways <= 1'b0;
      rxOn      <= 1'b0;
      irqNrt    <= 1'b0;
      irqGpt    <= 1'b0;
    end else begin
      if (strobe.start[T_NRT]) nrtAlways <= nrtAlwaysCfg;
      irqNrt <= hit[T_NRT];
      irqGpt <= hit[T_GPT];
      if (eot)                 rxOn <= (cfgMask == '0);
      else if (nrtForceLow)    rxOn <= 1'b0;
      else if (hit[T_MASK])    rxOn <= 1'b1;
    end
  end
endmodule

// File: rtl/rxwin_timers.sv
module rxwin_timers
  import rxwin_pkg::*;
#(
  parameter int TMR_W    = 8,
  parameter int LP_DIV   = 8,
  parameter int LONG_DIV = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             eot,
  input  logic             replyStart,
  input  logic             replyEnd,
  input  logic             replyBusy,
  input  logic             cmdClear,
  input  logic             cmdStartNrt,
  input  logic             cmdStartGpt,
  input  logic             lowPower,
  input  logic             nrtLong,
  input  logic             nrtAlwaysCfg,
  input  logic [1:0]       gptTrig,
  input  logic [TMR_W-1:0] cfgMask,
  input  logic [TMR_W-1:0] cfgNrt,
  input  logic [TMR_W-1:0] cfgGpt,
  output logic             rxOn,
  output logic             irqNrt,
  output logic             irqGpt
);
  localparam int PRE_W = $clog2(LONG_DIV > LP_DIV ? LONG_DIV : LP_DIV);

  tmrStrobe_t                    strobe;
  logic [NUM_TMR-1:0][TMR_W-1:0] loadVal;
  logic [NUM_TMR-1:0][PRE_W-1:0] divM1;
  logic [NUM_TMR-1:0]            hit;
  logic                          nrtAlways;

  assign loadVal[T_MASK] = cfgMask;
  assign loadVal[T_NRT]  = cfgNrt;
  assign loadVal[T_GPT]  = cfgGpt;

  rxwin_ctrl #(.TMR_W(TMR_W), .PRE_W(PRE_W), .LP_DIV(LP_DIV), .LONG_DIV(LONG_DIV)) u_ctrl (
    .clk(clk), .rst(rst), .eot(eot), .replyStart(replyStart), .replyEnd(replyEnd),
    .replyBusy(replyBusy), .cmdClear(cmdClear), .cmdStartNrt(cmdStartNrt),
    .cmdStartGpt(cmdStartGpt), .lowPower(lowPower), .nrtLong(nrtLong),
    .nrtAlwaysCfg(nrtAlwaysCfg), .gptTrig(gptTrig), .cfgMask(cfgMask), .hit(hit),
    .strobe(strobe), .divM1(divM1), .nrtAlways(nrtAlways), .rxOn(rxOn),
    .irqNrt(irqNrt), .irqGpt(irqGpt)
  );

  rxwin_dp #(.TMR_W(TMR_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rst(rst), .tick(tick), .strobe(strobe),
    .loadVal(loadVal), .divM1(divM1), .hit(hit)
  );
endmodule

// File: rtl/rxwin_chk.sv
module rxwin_chk #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             eot,
  input logic [TMR_W-1:0] cfgMask,
  input logic             replyBusy,
  input logic             nrtAlways,
  input logic             rxOn,
  input logic             irqNrt,
  input logic             irqGpt
);
  a_r2_mask_holds_low: assert property (@(posedge clk) disable iff (rst)
    (eot && cfgMask != '0) |=> !rxOn);

  a_r2_no_mask_opens: assert property (@(posedge clk) disable iff (rst)
    (eot && cfgMask == '0) |=> rxOn);

  a_r5_default_expiry_closes: assert property (@(posedge clk) disable iff (rst)
    (irqNrt && !nrtAlways) |-> !rxOn);

  a_r6_always_expiry_idle_closes: assert property (@(posedge clk) disable iff (rst)
    (irqNrt && nrtAlways && !$past(replyBusy)) |-> !rxOn);

  a_r12_nrt_irq_single: assert property (@(posedge clk) disable iff (rst)
    irqNrt |=> !irqNrt);

  a_r12_gpt_irq_single: assert property (@(posedge clk) disable iff (rst)
    irqGpt |=> !irqGpt);
endmodule

bind rxwin_timers rxwin_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst(rst), .eot(eot), .cfgMask(cfgMask), .replyBusy(replyBusy),
  .nrtAlways(nrtAlways), .rxOn(rxOn), .irqNrt(irqNrt), .irqGpt(irqGpt)
);

// File: tb/sim_rxwin_timers.sv
`timescale 1ns/1ps
module sim_rxwin_timers;
  localparam int TMR_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, eot = 0, replyStart = 0, replyEnd = 0, replyBusy = 0;
  logic cmdClear = 0, cmdStartNrt = 0, cmdStartGpt = 0;
  logic lowPower = 0, nrtLong = 0, nrtAlwaysCfg = 0;
  logic [1:0] gptTrig = 0;
  logic [TMR_W-1:0] cfgMask = 0, cfgNrt = 0, cfgGpt = 0;
  logic rxOn, irqNrt, irqGpt;

  always #10 clk = ~clk;

  rxwin_timers #(.TMR_W(TMR_W)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .eot(eot), .replyStart(replyStart),
    .replyEnd(replyEnd), .replyBusy(replyBusy), .cmdClear(cmdClear),
    .cmdStartNrt(cmdStartNrt), .cmdStartGpt(cmdStartGpt), .lowPower(lowPower),
    .nrtLong(nrtLong), .nrtAlwaysCfg(nrtAlwaysCfg), .gptTrig(gptTrig),
    .cfgMask(cfgMask), .cfgNrt(cfgNrt), .cfgGpt(cfgGpt),
    .rxOn(rxOn), .irqNrt(irqNrt), .irqGpt(irqGpt)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  string phaseTag = "R1";

  // behavioural reference: remaining ticks per timer
  int mRem[3];
  bit mRun[3];
  bit mAlways, mRxOn, mIrqN, mIrqG;

  task automatic modelReset();
    for (int i = 0; i < 3; i++) begin mRem[i] = 0; mRun[i] = 0; end
    mAlways = 0; mRxOn = 0; mIrqN = 0; mIrqG = 0;
  endtask

  task automatic modelStep();
    bit st[3], sp[3], ht[3];
    int val[3], dv[3];
    bit low;
    st[0] = eot; st[1] = eot || cmdStartNrt;
    st[2] = cmdStartGpt || (gptTrig == 2'd1 && replyStart) || (gptTrig == 2'd2 && replyEnd);
    sp[0] = cmdClear; sp[1] = !mAlways && (cmdClear || replyStart); sp[2] = cmdClear;
    val[0] = int'(cfgMask); val[1] = int'(cfgNrt); val[2] = int'(cfgGpt);
    dv[0] = lowPower ? 8 : 1; dv[1] = nrtLong ? 64 : 1; dv[2] = 1;
    for (int i = 0; i < 3; i++)
      ht[i] = mRun[i] && tick && mRem[i] == 1 && !st[i] && !sp[i];
    low = ht[1] && (!mAlways || !replyBusy);
    for (int i = 0; i < 3; i++) begin
      if (st[i]) begin mRun[i] = (val[i] != 0); mRem[i] = val[i] * dv[i]; end
      else if (sp[i]) mRun[i] = 0;
      else if (mRun[i] && tick) begin
        mRem[i]--;
        if (mRem[i] == 0) mRun[i] = 0;
      end
    end
    if (st[1]) mAlways = nrtAlwaysCfg;
    mIrqN = ht[1]; mIrqG = ht[2];
    if (eot) mRxOn = (cfgMask == 0);
    else if (low) mRxOn = 0;
    else if (ht[0]) mRxOn = 1;
  endtask

  task automatic expectEq(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: model advances with current inputs, compare after the edge
  task automatic cycle();
    if (!rst) modelStep(); else modelReset();
    @(negedge clk);
    expectEq(phaseTag, "rxOn",   int'(rxOn),   int'(mRxOn));
    expectEq(phaseTag, "irqNrt", int'(irqNrt), int'(mIrqN));
    expectEq(phaseTag, "irqGpt", int'(irqGpt), int'(mIrqG));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic pulseEot();     eot = 1; cycle(); eot = 0; endtask
  task automatic pulseClear();   cmdClear = 1; cycle(); cmdClear = 0; endtask
  task automatic pulseGpt();     cmdStartGpt = 1; cycle(); cmdStartGpt = 0; endtask
  task automatic pulseRxStart(); replyStart = 1; cycle(); replyStart = 0; endtask
  task automatic pulseRxEnd();   replyEnd = 1; cycle(); replyEnd = 0; endtask

  // cycles until the chosen output is 1 (0 rxOn, 1 irqNrt, 2 irqGpt)
  task automatic countUntil(int which, output int n);
    logic s;
    n = 0;
    do begin
      cycle(); n++;
      s = (which == 0) ? rxOn : (which == 1) ? irqNrt : irqGpt;
    end while (!s && n < 300);
  endtask

  task automatic countIrq(int which, int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      cycle();
      if ((which == 1 && irqNrt) || (which == 2 && irqGpt)) n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int n;
    modelReset();
    repeat (3) @(negedge clk);
    phaseTag = "R1";
    expectEq("R1", "rxOn in reset", int'(rxOn), 0);
    expectEq("R1", "irq in reset", int'(irqNrt | irqGpt), 0);
    rst = 0;
    tick = 1;
    run(4);

    phaseTag = "R2";
    cfgMask = 3; cfgNrt = 0;
    pulseEot();
    expectEq("R2", "rxOn after eot masked", int'(rxOn), 0);
    run(5);
    cfgMask = 0;
    pulseEot();
    expectEq("R2", "rxOn after eot unmasked", int'(rxOn), 1);
    run(2);

    phaseTag = "R3";
    lowPower = 1; cfgMask = 2;
    pulseEot();
    countUntil(0, n);
    expectEq("R3", "low-power mask cycles", n, 16);
    lowPower = 0; cfgMask = 5;
    pulseEot();
    countUntil(0, n);
    expectEq("R3", "mask cycles", n, 5);
    countIrq(1, 5, n);
    expectEq("R3", "mask raises no irq", n, 0);

    phaseTag = "R4";
    cfgMask = 0; nrtLong = 1; cfgNrt = 1;
    pulseEot();
    countUntil(1, n);
    expectEq("R4", "long step cycles", n, 64);
    nrtLong = 0; cfgNrt = 7;
    pulseEot();
    countUntil(1, n);
    expectEq("R4", "short step cycles", n, 7);

    phaseTag = "R5";
    cfgNrt = 3;
    pulseEot();
    countUntil(1, n);
    expectEq("R5", "default expiry cycles", n, 3);
    expectEq("R5", "rxOn closed at expiry", int'(rxOn), 0);
    cfgNrt = 6;
    pulseEot(); run(2); pulseRxStart();
    countIrq(1, 12, n);
    expectEq("R5", "reply first suppresses irq", n, 0);

    phaseTag = "R6";
    nrtAlwaysCfg = 1; cfgNrt = 4; replyBusy = 1;
    pulseEot(); pulseRxStart();
    countUntil(1, n);
    expectEq("R6", "always irq despite reply", n, 3);
    expectEq("R6", "rxOn kept while busy", int'(rxOn), 1);
    replyBusy = 0;
    pulseEot();
    countUntil(1, n);
    expectEq("R6", "always expiry idle cycles", n, 4);
    expectEq("R6", "rxOn closed when idle", int'(rxOn), 0);

    phaseTag = "R7";
    cfgMask = 0;
    pulseEot(); run(1); pulseClear();
    countIrq(1, 8, n);
    expectEq("R7", "clear ignored in always mode", n, 1);
    nrtAlwaysCfg = 0; cfgGpt = 5; cfgMask = 6;
    pulseEot(); pulseGpt(); pulseClear();
    countIrq(1, 10, n);
    expectEq("R7", "clear stops nrt", n, 0);
    expectEq("R7", "clear stops mask", int'(rxOn), 0);

    phaseTag = "R8";
    cfgMask = 0; cfgGpt = 4;
    pulseGpt(); run(2); pulseGpt();
    countUntil(2, n);
    expectEq("R8", "gpt restart cycles", n, 4);
    cfgNrt = 5;
    cmdStartNrt = 1; cycle(); cmdStartNrt = 0;
    run(3);
    cmdStartNrt = 1; cycle(); cmdStartNrt = 0;
    countUntil(1, n);
    expectEq("R8", "nrt restart cycles", n, 5);

    phaseTag = "R9";
    cfgGpt = 3; gptTrig = 2'd1;
    pulseRxStart();
    countUntil(2, n);
    expectEq("R9", "trigger on reply start", n, 3);
    gptTrig = 2'd2;
    pulseRxEnd();
    countUntil(2, n);
    expectEq("R9", "trigger on reply end", n, 3);
    gptTrig = 2'd0;
    pulseRxStart(); pulseRxEnd();
    countIrq(2, 8, n);
    expectEq("R9", "command-only ignores reply", n, 0);

    phaseTag = "R10";
    cfgGpt = 0; cfgNrt = 0;
    pulseGpt(); pulseEot();
    countIrq(2, 20, n);
    expectEq("R10", "zero gpt never fires", n, 0);
    expectEq("R10", "zero nrt never fires", int'(irqNrt), 0);

    phaseTag = "R11";
    cfgGpt = 3;
    pulseGpt();
    cfgGpt = 20;
    countUntil(2, n);
    expectEq("R11", "value latched at start", n, 3);

    phaseTag = "R12";
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom_range(0, 2) != 0);
      eot = ($urandom_range(0, 24) == 0);
      replyStart = ($urandom_range(0, 15) == 0);
      replyEnd = ($urandom_range(0, 15) == 0);
      replyBusy = ($urandom_range(0, 1) == 1);
      cmdClear = ($urandom_range(0, 40) == 0);
      cmdStartNrt = ($urandom_range(0, 30) == 0);
      cmdStartGpt = ($urandom_range(0, 20) == 0);
      if ($urandom_range(0, 15) == 0) begin
        lowPower = $urandom_range(0, 1);
        nrtLong = ($urandom_range(0, 5) == 0);
        nrtAlwaysCfg = $urandom_range(0, 1);
        gptTrig = 2'($urandom_range(0, 3));
        cfgMask = TMR_W'($urandom_range(0, 6));
        cfgNrt = TMR_W'($urandom_range(0, 9));
        cfgGpt = TMR_W'($urandom_range(0, 7));
      end
      cycle();
    end
    eot = 0; replyStart = 0; replyEnd = 0; cmdClear = 0; cmdStartNrt = 0; cmdStartGpt = 0;
    run(2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule